// File: doc/BRIEF.md
# Snapshot Sign-Majority Timing Detector

This block judges whether one receive phase bin of a serial lane sits early. On a start pulse it latches which bin to test, either the pre-cursor bin or the long bin. It then runs five snapshot cycles with an external snapshot engine. Each cycle waits for the engine's done line to be low, raises a start request with the bin code on a selector output, waits for done, and takes one sample from the returned data word. Every sample whose sign is set counts as one negative vote.

After the fifth sample the block pulses a valid strobe for one cycle, together with the early verdict. The verdict needs a larger majority for the pre-cursor bin than for the long bin. Each of the two waits is capped, so a snapshot engine that is stuck or silent cannot hang the block. A request that arrives while a decision is still running does nothing.

Top module: `snapVoteDetector`

## Requirements
- R1: A decision performs exactly five snapshot handshakes, which means five rising edges of `snapStart` between the accepted request and `resultValid`.
- R2: The sample's sign is bit 8 of the 10-bit field held in bits [15:6] of `snapData`, which is word bit 14. When this bit is 1 the sample is negative. All other word bits have no effect on the verdict.
- R3: When `reqBinLong` is 0 at the request, the selector carries code 6 and the verdict is early only when 4 or 5 of the samples are negative.
- R4: When `reqBinLong` is 1 at the request, the selector carries code 7 and the verdict is early when 3, 4 or 5 of the samples are negative.
- R5: Before each snapshot the block waits for `snapDone` to be sampled low. It raises `snapStart` in the cycle after that.
- R6: `snapStart` stays high until `snapDone` is sampled high. The sample is taken at that clock edge, and `snapStart` is low in the following cycle.
- R7: Each wait lasts at most 100 cycles. When the clear-wait times out, `snapStart` is raised anyway. When the done-wait times out, the current `snapData` is sampled and `snapStart` drops.
- R8: `resultValid` is high for exactly one cycle, the cycle after the clock edge that takes the fifth sample. `resultEarly` is qualified by it.
- R9: A `reqStart` that arrives while a decision is running is ignored. It changes neither the selector, nor the verdict, nor the number of snapshots, and it starts no new decision.
- R10: A synchronous active-high `rst` drops `snapStart` and `resultValid` and abandons any decision in progress.
- R11: `snapBinSel` holds a valid bin code and stays unchanged for as long as `snapStart` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqStart | input | 1 | One-cycle request to start a decision |
| reqBinLong | input | 1 | Bin choice sampled with the request: 0 pre-cursor, 1 long |
| snapDone | input | 1 | Snapshot engine done flag |
| snapData | input | 16 | Snapshot word returned by the engine |
| snapStart | output | 1 | Snapshot start request to the engine |
| snapBinSel | output | 3 | Bin selector code for the engine (6 or 7) |
| resultValid | output | 1 | One-cycle strobe marking a verdict |
| resultEarly | output | 1 | Verdict: the selected bin is early |

## Verification
The assertions assume that the snapshot engine changes `snapDone` and `snapData` only between clock edges, and that `reqStart` is a clean synchronous pulse. The engine model in the stimulus updates its outputs on the falling clock edge only. It covers prompt and delayed responses, a done line stuck high and a done line that never rises, so both timeout paths are taken. It also issues requests during busy periods and resets in the middle of a decision, so the ignore rule and the abandon rule are both exercised.

// File: rtl/snapVotePkg.sv
package snapVotePkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_CLR,
    ST_WAIT_DONE,
    ST_FINISH
  } voteState_t;

  // strobes from the sequencer to the tally datapath
  typedef struct packed {
    logic latchBin;
    logic clearCount;
    logic takeSample;
  } voteStrobe_t;

endpackage

// File: rtl/snapVoteCtrl.sv
module snapVoteCtrl
  import snapVotePkg::*;
#(
  parameter int NUM_SNAPS  = 5,
  parameter int WAIT_LIMIT = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqStart,
  input  logic        snapDone,
  output logic        snapStart,
  output logic        finishing,
  output voteStrobe_t strobe
);

  localparam int IDX_W  = $clog2(NUM_SNAPS + 1);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);

  voteState_t        state;
  logic [IDX_W-1:0]  snapIdx;
  logic [WAIT_W-1:0] waitCnt;
  logic              waitExpired;
  logic              lastSnap;

  assign waitExpired = (waitCnt == WAIT_W'(WAIT_LIMIT - 1));
  assign lastSnap    = (snapIdx == IDX_W'(NUM_SNAPS - 1));
  assign finishing   = (state == ST_FINISH);

  always_comb begin
    strobe            = '0;
    strobe.latchBin   = (state == ST_IDLE) && reqStart;
    strobe.clearCount = (state == ST_IDLE) && reqStart;
    strobe.takeSample = (state == ST_WAIT_DONE) && (snapDone || waitExpired);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      snapStart <= 1'b0;
      snapIdx   <= '0;
      waitCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqStart) begin
            state   <= ST_WAIT_CLR;
            snapIdx <= '0;
            waitCnt <= '0;
          end
        end
        ST_WAIT_CLR: begin
          // engine must be idle before a new request, or the wait times out
          if (!snapDone || waitExpired) begin
            state     <= ST_WAIT_DONE;
            snapStart <= 1'b1;
            waitCnt   <= '0;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        ST_WAIT_DONE: begin
          if (strobe.takeSample) begin
            snapStart <= 1'b0;
            waitCnt   <= '0;
            snapIdx   <= snapIdx + IDX_W'(1);
            state     <= lastSnap ? ST_FINISH : ST_WAIT_CLR;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snapVoteDatapath.sv
module snapVoteDatapath
  import snapVotePkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FIELD_LSB   = 6,
  parameter int FIELD_W     = 10,
  parameter int SIGN_POS    = 8,
  parameter int NUM_SNAPS   = 5,
  parameter int SEL_W       = 3,
  parameter int PRE_CODE    = 6,
  parameter int LONG_CODE   = 7,
  parameter int PRE_THRESH  = 3,
  parameter int LONG_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqBinLong,
  input  voteStrobe_t       strobe,
  input  logic [WORD_W-1:0] snapData,
  output logic [SEL_W-1:0]  snapBinSel,
  output logic              isEarly
);

  localparam int CNT_W = $clog2(NUM_SNAPS + 1);

  logic [FIELD_W-1:0] snapField;
  logic               sampleNeg;
  logic               unusedWordBits;
  logic               binIsLong;
  logic [CNT_W-1:0]   negCount;
  logic [CNT_W-1:0]   voteThresh;

  assign snapField      = snapData[FIELD_LSB +: FIELD_W];
  assign sampleNeg      = snapField[SIGN_POS];
  assign unusedWordBits = ^snapData;

  always_ff @(posedge clk) begin
    if (rst) begin
      binIsLong <= 1'b0;
      negCount  <= '0;
    end else begin
      if (strobe.latchBin) binIsLong <= reqBinLong;
      if (strobe.clearCount)      negCount <= '0;
      else if (strobe.takeSample) negCount <= negCount + CNT_W'(sampleNeg);
    end
  end

  assign snapBinSel = binIsLong ? SEL_W'(LONG_CODE) : SEL_W'(PRE_CODE);
  assign voteThresh = binIsLong ? CNT_W'(LONG_THRESH) : CNT_W'(PRE_THRESH);
  assign isEarly    = (negCount > voteThresh);

endmodule

// File: rtl/snapVoteDetector.sv
module snapVoteDetector
  import snapVotePkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FIELD_LSB   = 6,
  parameter int FIELD_W     = 10,
  parameter int SIGN_POS    = 8,
  parameter int NUM_SNAPS   = 5,
  parameter int WAIT_LIMIT  = 100,
  parameter int SEL_W       = 3,
  parameter int PRE_CODE    = 6,
  parameter int LONG_CODE   = 7,
  parameter int PRE_THRESH  = 3,
  parameter int LONG_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqStart,
  input  logic              reqBinLong,
  input  logic              snapDone,
  input  logic [WORD_W-1:0] snapData,
  output logic              snapStart,
  output logic [SEL_W-1:0]  snapBinSel,
  output logic              resultValid,
  output logic              resultEarly
);

  voteStrobe_t strobe;
  logic        finishing;
  logic        isEarly;

  snapVoteCtrl #(
    .NUM_SNAPS (NUM_SNAPS),
    .WAIT_LIMIT(WAIT_LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqStart (reqStart),
    .snapDone (snapDone),
    .snapStart(snapStart),
    .finishing(finishing),
    .strobe   (strobe)
  );

  snapVoteDatapath #(
    .WORD_W     (WORD_W),
    .FIELD_LSB  (FIELD_LSB),
    .FIELD_W    (FIELD_W),
    .SIGN_POS   (SIGN_POS),
    .NUM_SNAPS  (NUM_SNAPS),
    .SEL_W      (SEL_W),
    .PRE_CODE   (PRE_CODE),
    .LONG_CODE  (LONG_CODE),
    .PRE_THRESH (PRE_THRESH),
    .LONG_THRESH(LONG_THRESH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .reqBinLong(reqBinLong),
    .strobe    (strobe),
    .snapData  (snapData),
    .snapBinSel(snapBinSel),
    .isEarly   (isEarly)
  );

  assign resultValid = finishing;
  assign resultEarly = finishing & isEarly;

endmodule

// File: rtl/snapVoteDetector_chk.sv
module snapVoteDetector_chk #(
  parameter int WAIT_LIMIT = 100,
  parameter int NUM_SNAPS  = 5,
  parameter int SEL_W      = 3,
  parameter int PRE_CODE   = 6,
  parameter int LONG_CODE  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             snapDone,
  input logic             snapStart,
  input logic [SEL_W-1:0] snapBinSel,
  input logic             resultValid
);

  int   hiWait;
  int   riseCnt;
  logic prevStart;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiWait    <= 0;
      riseCnt   <= 0;
      prevStart <= 1'b0;
    end else begin
      prevStart <= snapStart;
      if (!snapStart)     hiWait <= 0;
      else if (!snapDone) hiWait <= hiWait + 1;
      if (resultValid)                   riseCnt <= 0;
      else if (snapStart && !prevStart)  riseCnt <= riseCnt + 1;
    end
  end

  // R1: five handshakes per verdict
  a_r1_five_snaps: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (riseCnt == NUM_SNAPS));

  // R6: start held while done is low and the wait has not expired
  a_r6_start_held: assert property (@(posedge clk) disable iff (rst)
    (snapStart && !snapDone && (hiWait < WAIT_LIMIT - 1)) |=> snapStart);

  // R6: start released once done is seen
  a_r6_start_drop: assert property (@(posedge clk) disable iff (rst)
    (snapStart && snapDone) |=> !snapStart);

  // R8: valid is a single-cycle strobe
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  // R10: reset clears the request and the strobe
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!snapStart && !resultValid));

  // R11: selector legal and steady while start is high
  a_r11_sel_legal: assert property (@(posedge clk) disable iff (rst)
    snapStart |-> (snapBinSel == SEL_W'(PRE_CODE) || snapBinSel == SEL_W'(LONG_CODE)));

  a_r11_sel_stable: assert property (@(posedge clk) disable iff (rst)
    snapStart |=> (!snapStart || $stable(snapBinSel)));

endmodule

bind snapVoteDetector snapVoteDetector_chk #(
  .WAIT_LIMIT(WAIT_LIMIT),
  .NUM_SNAPS (NUM_SNAPS),
  .SEL_W     (SEL_W),
  .PRE_CODE  (PRE_CODE),
  .LONG_CODE (LONG_CODE)
) u_chk (.*);

// File: tb/snapVoteDetector_bench.sv
`timescale 1ns/1ps
module snapVoteDetector_bench;

  localparam int WAIT_LIMIT = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqStart = 1'b0;
  logic        reqBinLong = 1'b0;
  logic        snapDone = 1'b0;
  logic [15:0] snapData = '0;
  logic        snapStart;
  logic [2:0]  snapBinSel;
  logic        resultValid;
  logic        resultEarly;

  always #2.5 clk = ~clk;

  snapVoteDetector u_snapVoteDetector (
    .clk        (clk),
    .rst        (rst),
    .reqStart   (reqStart),
    .reqBinLong (reqBinLong),
    .snapDone   (snapDone),
    .snapData   (snapData),
    .snapStart  (snapStart),
    .snapBinSel (snapBinSel),
    .resultValid(resultValid),
    .resultEarly(resultEarly)
  );

  int    compared = 0;
  int    mismatched = 0;
  string testTag = "reset";
  bit    checkOn = 0;

  function automatic void chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s [%s]: actual %0d expected %0d", tag, what, testTag, act, exp);
    end
  endfunction

  // ---------------- snapshot engine model ----------------
  int          doneDelay = 0, relDelay = 0, dlyCnt = 0, relCnt = 0;
  bit          stuckHigh = 0, neverDone = 0;
  logic [15:0] presetWord = '0;
  logic [15:0] dataQ[$];

  always @(negedge clk) begin
    if (stuckHigh) begin
      snapDone = 1'b1;
      snapData = presetWord;
    end else if (neverDone) begin
      snapDone = 1'b0;
      snapData = presetWord;
    end else if (snapStart && !snapDone) begin
      relCnt = 0;
      if (dlyCnt >= doneDelay) begin
        snapDone = 1'b1;
        snapData = (dataQ.size() > 0) ? dataQ.pop_front() : 16'h0000;
        dlyCnt = 0;
      end else dlyCnt++;
    end else if (!snapStart && snapDone) begin
      dlyCnt = 0;
      if (relCnt >= relDelay) begin
        snapDone = 1'b0;
        relCnt = 0;
      end else relCnt++;
    end else begin
      dlyCnt = 0;
      relCnt = 0;
    end
  end

  // ---------------- reference model ----------------
  int mPh = 0, mNeg = 0, mIdx = 0, mWait = 0;
  bit mLong = 0, mStart = 0;

  always @(posedge clk) begin
    if (rst) begin
      mPh = 0; mStart = 0; mNeg = 0; mIdx = 0; mWait = 0;
    end else begin
      case (mPh)
        0: if (reqStart) begin
             mLong = reqBinLong; mNeg = 0; mIdx = 0; mWait = 0; mPh = 1;
           end
        1: if (!snapDone || mWait == WAIT_LIMIT - 1) begin
             mPh = 2; mStart = 1; mWait = 0;
           end else mWait++;
        2: if (snapDone || mWait == WAIT_LIMIT - 1) begin
             if (snapData[14]) mNeg++;
             mStart = 0; mWait = 0; mIdx++;
             mPh = (mIdx == 5) ? 3 : 1;
           end else mWait++;
        default: mPh = 0;
      endcase
    end
  end

  // ---------------- per-clock comparison ----------------
  int rises = 0;
  bit prevS = 0;

  always @(negedge clk) begin
    if (checkOn) begin
      if (snapStart && !prevS) rises++;
      prevS = snapStart;
      chk("R6", "snapStart", snapStart, mStart);
      chk("R8", "resultValid", resultValid, (mPh == 3));
      if (mStart) chk(mLong ? "R4" : "R3", "snapBinSel", snapBinSel, mLong ? 7 : 6);
      if (mPh == 3) begin
        chk(mLong ? "R4" : "R3", "resultEarly", resultEarly, (mNeg > (mLong ? 2 : 3)));
        chk("R1", "snapshot count", rises, 5);
      end
      if (mPh == 0) rises = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pushWords(input logic [15:0] a, b, c, d, e);
    dataQ.push_back(a); dataQ.push_back(b); dataQ.push_back(c);
    dataQ.push_back(d); dataQ.push_back(e);
  endtask

  task automatic request(input bit lng);
    @(negedge clk);
    reqStart = 1'b1; reqBinLong = lng;
    @(negedge clk);
    reqStart = 1'b0; reqBinLong = 1'b0;
  endtask

  task automatic decide(input bit lng, input bit expEarly, input string tag);
    request(lng);
    while (!resultValid) @(negedge clk);
    chk(tag, "verdict", resultEarly, expEarly);
    repeat (8) @(negedge clk);
  endtask

  localparam logic [15:0] NEG = 16'hFFFF;  // sign bit 14 set, everything else set
  localparam logic [15:0] POS = 16'hBFFF;  // only bit 14 clear

  task automatic runAll();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkOn = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "start after reset", snapStart, 0);
    chk("R10", "valid after reset", resultValid, 0);

    // R2, R3: pre-cursor bin, 3 negatives is not a majority
    testTag = "R2 R3 three neg";
    pushWords(NEG, POS, NEG, POS, NEG);
    decide(1'b0, 1'b0, "R3");
    // R3: 4 negatives -> early
    testTag = "R3 four neg";
    doneDelay = 3; relDelay = 2;
    pushWords(NEG, NEG, POS, NEG, NEG);
    decide(1'b0, 1'b1, "R3");
    // R4: long bin, 3 negatives -> early
    testTag = "R4 three neg";
    doneDelay = 1; relDelay = 4;
    pushWords(POS, NEG, NEG, POS, NEG);
    decide(1'b1, 1'b1, "R4");
    // R4: long bin, 2 negatives -> not early
    testTag = "R4 two neg";
    doneDelay = 0; relDelay = 0;
    pushWords(NEG, POS, POS, NEG, POS);
    decide(1'b1, 1'b0, "R4");
    // R2: only non-sign bits toggled -> zero negatives
    testTag = "R2 other bits";
    pushWords(16'h3FFF, 16'h8000, 16'hBFC0, 16'h003F, 16'h2000);
    decide(1'b1, 1'b0, "R2");
    // R5: slow release of done delays each next start
    testTag = "R5 slow release";
    doneDelay = 2; relDelay = 9;
    pushWords(NEG, NEG, NEG, NEG, NEG);
    decide(1'b0, 1'b1, "R5");

    // R9: request while busy is ignored
    testTag = "R9 busy request";
    doneDelay = 3; relDelay = 1;
    pushWords(NEG, NEG, NEG, POS, POS);
    request(1'b0);
    repeat (4) @(negedge clk);
    reqStart = 1'b1; reqBinLong = 1'b1;
    @(negedge clk);
    reqStart = 1'b0; reqBinLong = 1'b0;
    while (!resultValid) @(negedge clk);
    chk("R9", "verdict unchanged (pre bin)", resultEarly, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9", "no new decision", snapStart, 0);
    end

    // R7: done never rises -> done-wait timeout, current data sampled
    testTag = "R7 done timeout";
    presetWord = 16'h4000; neverDone = 1;
    decide(1'b0, 1'b1, "R7");
    neverDone = 0;
    // R7: done stuck high -> clear-wait timeout, start raised anyway
    testTag = "R7 clear timeout";
    presetWord = 16'h0000; stuckHigh = 1;
    repeat (2) @(negedge clk);
    decide(1'b1, 1'b0, "R7");
    stuckHigh = 0;
    repeat (6) @(negedge clk);

    // R10: reset mid-decision abandons it
    testTag = "R10 reset mid";
    doneDelay = 4; relDelay = 0;
    pushWords(NEG, NEG, NEG, NEG, NEG);
    request(1'b1);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R10", "start after mid reset", snapStart, 0);
    chk("R10", "valid after mid reset", resultValid, 0);
    dataQ.delete();
    repeat (8) @(negedge clk);
    testTag = "R3 after reset";
    doneDelay = 0;
    pushWords(POS, POS, POS, POS, POS);
    decide(1'b0, 1'b0, "R3");
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule